// File: doc/BRIEF.md
# Event Time Capture with Lockout

This block freezes a copy of the running time, counted in 100 ns ticks, whenever one of three triggers fires. The triggers are an edge on an asynchronous external event pin, a one-cycle pulse from a periodic generator, and a host write strobe to the unlock location. The edge on the event pin can be rising or falling, chosen by a select input. Event and periodic triggers each have their own enable bit. A host write always requests a capture.

After a capture, a lockout holds the captured value. No later trigger can replace it until the host reads the unlock location. A flag shows the host that an unread capture is waiting. The capture register is separate from the live time input, so the running time keeps advancing while the frozen value stays put. The lockout is held in one state bit, and that bit is the flag.

Top module: `evt_capture_lock`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, cap_time is 0 and cap_valid is 0.
- R2: With evt_en=1 and edge_fall=0, a rising level change on ext_evt causes a capture. Count as edge 1 the first clk rising edge that samples the new level. cap_valid is 1 and cap_time holds the time_in value sampled at edge 3. At edges 1 and 2, cap_valid is still 0.
- R3: edge_fall selects the active edge of ext_evt: 0 selects rising, 1 selects falling. A change in the other direction causes no capture.
- R4: With per_en=1, a high per_pulse in a cycle captures time_in at the next clk edge and sets cap_valid.
- R5: With evt_en=0, ext_evt edges cause no capture. With per_en=0, per_pulse causes no capture. In both cases cap_valid stays 0.
- R6: host_wr=1 captures time_in at the next clk edge whatever the enable bits are, and sets cap_valid.
- R7: While cap_valid=1, every trigger (event edge, periodic pulse, host write) leaves cap_time unchanged.
- R8: host_rd=1 while cap_valid=1 clears cap_valid at the next edge and leaves cap_time unchanged. Any trigger in that same cycle is ignored. host_rd while cap_valid=0 has no effect.
- R9: Triggers that coincide in one cycle produce exactly one capture, of the time_in value present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_in | input | TIME_W | Running time, 100 ns per count |
| ext_evt | input | 1 | Asynchronous external event pin |
| edge_fall | input | 1 | Active event edge: 0 rising, 1 falling |
| evt_en | input | 1 | Enables external event captures |
| per_pulse | input | 1 | One-cycle pulse from the periodic generator |
| per_en | input | 1 | Enables periodic captures |
| host_wr | input | 1 | Host write strobe to the unlock location (forces a capture) |
| host_rd | input | 1 | Host read strobe to the unlock location (releases the lockout) |
| cap_time | output | TIME_W | Captured time |
| cap_valid | output | 1 | An unread capture is held (lockout engaged) |

## Verification
The case that is hardest to reach from the ports is a release read that lands in the same cycle as a trigger while the lockout is engaged. In that cycle the trigger must be lost, and the old value must survive the release. The vector table reaches this state by chaining one step after another: a periodic capture, then blocked retriggers, then a combined read-and-pulse step. The external event path is tested separately, by changing ext_evt at half-cycle points and checking the flag at each of the three synchronizer edges. Time_in changes on each of those cycles, so a capture at the wrong edge shows up as a wrong value.

// File: rtl/etc_pkg.sv
package etc_pkg;
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_mode_e;
endpackage

// File: rtl/etc_edge_sync.sv
module etc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_fall,
    output logic edge_hit
);
    import etc_pkg::*;

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sh;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    edge_mode_e mode;

    always_comb begin
        st_d = st_q;
        st_d.prev = st_q.sh[TOP];
        if (SYNC_STAGES > 1) begin
            st_d.sh = {st_q.sh[TOP-1:0], pin};
        end else begin
            st_d.sh[0] = pin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode = edge_mode_e'(edge_fall);

    always_comb begin
        if (mode == EDGE_FALL) edge_hit = st_q.prev & ~st_q.sh[TOP];
        else                   edge_hit = st_q.sh[TOP] & ~st_q.prev;
    end

    // A level change is reported once only (R2)
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && $stable(edge_fall)) |=> !edge_hit);
endmodule

// File: rtl/etc_trig_arb.sv
module etc_trig_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_hit,
    input  logic evt_en,
    input  logic per_pulse,
    input  logic per_en,
    input  logic host_wr,
    input  logic host_rd,
    output logic take,
    output logic locked
);
    typedef struct packed {
        logic lock;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    any_trig;

    always_comb begin
        any_trig = (evt_hit & evt_en) | (per_pulse & per_en) | host_wr;
        take     = any_trig & ~st_q.lock;
        st_d     = st_q;
        if (take)         st_d.lock = 1'b1;
        else if (host_rd) st_d.lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;

    assert_lock_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> locked);
    assert_release_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && host_rd) |=> !locked);
    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !host_rd) |=> locked);
endmodule

// File: rtl/etc_cap_reg.sv
module etc_cap_reg #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [TIME_W-1:0] time_in,
    output logic [TIME_W-1:0] cap_time
);
    typedef struct packed {
        logic [TIME_W-1:0] val;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.val = time_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_time = st_q.val;

    assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cap_time == $past(time_in)));
    assert_hold_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cap_time));
endmodule

// File: rtl/evt_capture_lock.sv
module evt_capture_lock #(
    parameter int TIME_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_in,
    input  logic              ext_evt,
    input  logic              edge_fall,
    input  logic              evt_en,
    input  logic              per_pulse,
    input  logic              per_en,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [TIME_W-1:0] cap_time,
    output logic              cap_valid
);
    logic evt_hit;
    logic take;

    etc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_evt),
        .edge_fall(edge_fall), .edge_hit(evt_hit)
    );

    etc_trig_arb u_arb (
        .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .evt_en(evt_en),
        .per_pulse(per_pulse), .per_en(per_en), .host_wr(host_wr),
        .host_rd(host_rd), .take(take), .locked(cap_valid)
    );

    etc_cap_reg #(.TIME_W(TIME_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .take(take),
        .time_in(time_in), .cap_time(cap_time)
    );

    assert_frozen_while_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> $stable(cap_time));
    assert_write_captures_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !cap_valid) |=> cap_valid);
    assert_gated_sources_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid && !host_wr && !(per_en && per_pulse) && !evt_en) |=> !cap_valid);
endmodule

// File: tb/evt_capture_lock_tb.sv
module evt_capture_lock_tb;
    localparam int TW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] time_in = '0;
    logic          ext_evt = 1'b0, edge_fall = 1'b0, evt_en = 1'b0;
    logic          per_pulse = 1'b0, per_en = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [TW-1:0] cap_time;
    logic          cap_valid;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    evt_capture_lock #(.TIME_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .time_in(time_in), .ext_evt(ext_evt),
        .edge_fall(edge_fall), .evt_en(evt_en), .per_pulse(per_pulse),
        .per_en(per_en), .host_wr(host_wr), .host_rd(host_rd),
        .cap_time(cap_time), .cap_valid(cap_valid)
    );

    typedef struct packed {
        logic          pen, pp, wr, rd;
        logic [TW-1:0] tm;
        logic          ev;
        logic [TW-1:0] et;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0, 32'd10,  1'b0, 32'd0,   4'd5}, // R5 periodic disabled
        '{1'b1,1'b1,1'b0,1'b0, 32'd20,  1'b1, 32'd20,  4'd4}, // R4 periodic capture
        '{1'b1,1'b1,1'b0,1'b0, 32'd30,  1'b1, 32'd20,  4'd7}, // R7 retrigger blocked
        '{1'b0,1'b0,1'b1,1'b0, 32'd40,  1'b1, 32'd20,  4'd7}, // R7 write blocked
        '{1'b1,1'b1,1'b0,1'b1, 32'd50,  1'b0, 32'd20,  4'd8}, // R8 release, pulse lost
        '{1'b0,1'b0,1'b1,1'b0, 32'd60,  1'b1, 32'd60,  4'd6}, // R6 forced capture
        '{1'b0,1'b0,1'b0,1'b1, 32'd70,  1'b0, 32'd60,  4'd8}, // R8 release
        '{1'b1,1'b1,1'b1,1'b0, 32'd80,  1'b1, 32'd80,  4'd9}, // R9 coincident triggers
        '{1'b0,1'b0,1'b0,1'b0, 32'd90,  1'b1, 32'd80,  4'd9}, // R9 single capture held
        '{1'b0,1'b0,1'b0,1'b1, 32'd100, 1'b0, 32'd80,  4'd8}, // R8 release
        '{1'b0,1'b0,1'b0,1'b1, 32'd110, 1'b0, 32'd80,  4'd8}, // R8 read while unlocked
        '{1'b0,1'b0,1'b1,1'b1, 32'd120, 1'b1, 32'd120, 4'd8}, // R8 read+write unlocked
        '{1'b0,1'b0,1'b0,1'b1, 32'd130, 1'b0, 32'd120, 4'd8}  // R8 release
    };

    task automatic check(input string tag, input logic v_exp, input logic [TW-1:0] t_exp);
        total++;
        if (cap_valid !== v_exp || cap_time !== t_exp) begin
            bad++;
            $display("FAIL %s: valid=%0b time=%0d, expected valid=%0b time=%0d",
                     tag, cap_valid, cap_time, v_exp, t_exp);
        end
    endtask

    task automatic release_lock();
        @(negedge clk) host_rd = 1'b1;
        @(negedge clk) host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(2);
        check("R1 in reset", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, '0);

        for (int i = 0; i < NV; i++) begin
            per_en = VECS[i].pen; per_pulse = VECS[i].pp;
            host_wr = VECS[i].wr; host_rd = VECS[i].rd; time_in = VECS[i].tm;
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].ev, VECS[i].et);
        end
        per_en = 0; per_pulse = 0; host_wr = 0; host_rd = 0;

        // R2 rising event path: capture at third edge
        evt_en = 1'b1; edge_fall = 1'b0; time_in = 500;
        idle(1);
        ext_evt = 1'b1; time_in = 500;
        @(negedge clk); check("R2 edge1", 1'b0, 32'd120); time_in = 501;
        @(negedge clk); check("R2 edge2", 1'b0, 32'd120); time_in = 502;
        @(negedge clk); check("R2 edge3", 1'b1, 32'd502);
        release_lock();

        // R3 falling change ignored in rising mode
        time_in = 600; ext_evt = 1'b0; idle(5);
        check("R3 fall ignored", 1'b0, 32'd502);
        // R3 falling mode: rising ignored, falling captures
        edge_fall = 1'b1; idle(1);
        ext_evt = 1'b1; idle(5);
        check("R3 rise ignored", 1'b0, 32'd502);
        time_in = 700; ext_evt = 1'b0; idle(3);
        check("R3 fall capture", 1'b1, 32'd700);

        // R7 event edge while locked
        time_in = 750; ext_evt = 1'b1; idle(2); ext_evt = 1'b0; idle(4);
        check("R7 event locked", 1'b1, 32'd700);
        release_lock();

        // R5 event disabled
        evt_en = 1'b0; time_in = 800;
        ext_evt = 1'b1; idle(2); ext_evt = 1'b0; idle(4);
        check("R5 event disabled", 1'b0, 32'd700);

        // R1 reset while holding a capture
        host_wr = 1'b1; time_in = 900; @(negedge clk); host_wr = 1'b0;
        check("R6 before reset", 1'b1, 32'd900);
        rst_n = 1'b0; idle(1);
        check("R1 reset clears", 1'b0, '0);
        rst_n = 1'b1; idle(1);
        check("R1 after re-reset", 1'b0, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule